// File: doc/BRIEF.md
# Serial Register Command Responder

This block sits on the device side of a byte-wide serial link. It takes in the received byte stream and splits it into command frames. Each frame opens with a register address byte. A per-address lookup gives the number of data bytes that follow and tells whether the register is a configuration register or a query register. When a frame is complete, the block executes it:

- A configuration frame becomes a one-cycle write strobe to internal logic, carrying the address and the collected payload. The host then gets a single acknowledge byte.
- A query frame becomes a one-cycle request to an internal data source, carrying the address and any argument bytes. The source answers in the same cycle with a 64-bit word and a count of meaningful bytes. That word goes back to the host as exactly eight bytes, most significant first, with the unused high-order bytes forced to zero.

The block keeps in step with the host in three ways. It enforces the byte count of each register exactly. It discards received bytes while a reply is in flight. It drops a half-received frame after a configurable number of idle clock cycles.

Top module: `regcmd_responder`

## Requirements
- R1: After synchronous reset, `tx_valid`, `wr_strobe` and `qry_req` are low.
- R2: The register set is fixed, and the data byte counts are part of the frame format:
  - address 0x10 is a configuration register with 1 data byte;
  - address 0x11 is a configuration register with 2 data bytes;
  - address 0x12 is a configuration register with 4 data bytes;
  - address 0x20 is a query register with 1 argument byte, which selects the parameter group;
  - address 0x21 is a query register with 0 argument bytes.
- R3: A complete configuration frame raises `wr_strobe` for exactly one cycle, in the cycle after the last data byte is accepted. `wr_addr` carries the address. `wr_data` carries the data bytes right-aligned, with the first received byte most significant and all unused upper bits zero. Data bytes equal to zero are still required.
- R4: Each executed configuration write is answered by exactly one transmitted byte, 0x02 (bit 1 set).
- R5: A complete query frame raises `qry_req` for one cycle, with `qry_addr` and the right-aligned argument on `qry_arg`. It is answered by exactly eight transmitted bytes, taken from `qry_data` bits 63:56 first and bits 7:0 last.
- R6: Reply byte i, where byte 0 is `qry_data[7:0]`, carries `qry_data` only when i < `qry_len`; every other reply byte is 0x00.
- R7: A received address byte that is not in the register set is dropped. The parser stays idle, and the next byte is taken as a new address.
- R8: Bytes received while a reply is still pending are ignored and cause no strobe. Parsing restarts from idle once the last reply byte has been accepted.
- R9: If `TIMEOUT_CYCLES` consecutive cycles pass without a received byte while a frame is incomplete, the partial frame is abandoned and the next byte is taken as an address.
- R10: `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low. The next reply byte appears only after the current one has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte offered to transmitter |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| wr_strobe | output | 1 | Configuration write pulse |
| wr_addr | output | 8 | Address of the configuration write |
| wr_data | output | 32 | Right-aligned configuration payload |
| qry_req | output | 1 | Query request pulse |
| qry_addr | output | 8 | Address of the query |
| qry_arg | output | 32 | Right-aligned query argument bytes |
| qry_data | input | 64 | Query result from internal source, same cycle as request |
| qry_len | input | 4 | Number of meaningful low-order bytes in qry_data |

## Verification
The assertions check several properties on every cycle:
- the single-cycle width of the write strobe;
- the absence of any strobe while a reply is pending;
- a stable transmit byte under back-pressure;
- the acknowledge byte being loaded after each configuration write;
- the return to idle after an unknown address or an expired idle window;
- the transmit line going quiet after the last reply byte.

Whether the payload bytes end up in the right order and position, whether the zero padding of short query replies is correct, and whether the byte counts leave the parser aligned with the host across frames can only be shown by the bench. The bench does this by sending frame sequences and comparing the strobes and reply streams it logs against values it computes itself.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
    localparam int BYTE_W        = 8;
    localparam int PAYLOAD_BYTES = 4;
    localparam int PAYLOAD_W     = PAYLOAD_BYTES * BYTE_W;
    localparam int REPLY_BYTES   = 8;
    localparam int REPLY_W       = REPLY_BYTES * BYTE_W;
    localparam int CNT_W         = $clog2(PAYLOAD_BYTES + 1);
    localparam int LEFT_W        = $clog2(REPLY_BYTES + 1);
    localparam logic [BYTE_W-1:0] ACK_BYTE = 8'h02;

    typedef enum logic [1:0] {KIND_NONE, KIND_CFG, KIND_QRY} reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [CNT_W-1:0] nbytes;
    } reg_spec_t;

    typedef struct packed {
        reg_kind_e              kind;
        logic [BYTE_W-1:0]      addr;
        logic [PAYLOAD_W-1:0]   payload;
    } cmd_t;

    // Register set: kind and number of data bytes per address.
    function automatic reg_spec_t lookup_reg(input logic [BYTE_W-1:0] a);
        reg_spec_t s;
        s.kind   = KIND_NONE;
        s.nbytes = '0;
        case (a)
            8'h10: begin s.kind = KIND_CFG; s.nbytes = CNT_W'(1); end
            8'h11: begin s.kind = KIND_CFG; s.nbytes = CNT_W'(2); end
            8'h12: begin s.kind = KIND_CFG; s.nbytes = CNT_W'(4); end
            8'h20: begin s.kind = KIND_QRY; s.nbytes = CNT_W'(1); end
            8'h21: begin s.kind = KIND_QRY; s.nbytes = CNT_W'(0); end
            default: ;
        endcase
        return s;
    endfunction

    // Keep the n low-order bytes, zero the rest.
    function automatic logic [REPLY_W-1:0] mask_reply(input logic [REPLY_W-1:0] d,
                                                       input logic [LEFT_W-1:0] n);
        logic [REPLY_W-1:0] r;
        r = '0;
        for (int i = 0; i < REPLY_BYTES; i++) begin
            if (i < int'(n)) r[i*BYTE_W +: BYTE_W] = d[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/regcmd_parser.sv
module regcmd_parser
    import regcmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              reply_done,
    output logic              cmd_fire,
    output cmd_t              cmd
);
    localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

    typedef enum logic [1:0] {P_IDLE, P_COLLECT, P_BUSY} pstate_e;

    pstate_e          state;
    reg_spec_t        spec;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] got;
    logic [TMR_W-1:0] idle_tmr;

    assign spec = lookup_reg(rx_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= P_IDLE;
            cmd_fire <= 1'b0;
            cmd      <= '0;
            need     <= '0;
            got      <= '0;
            idle_tmr <= '0;
        end else begin
            cmd_fire <= 1'b0;
            case (state)
                P_IDLE: begin
                    if (rx_valid && spec.kind != KIND_NONE) begin
                        cmd.kind    <= spec.kind;
                        cmd.addr    <= rx_data;
                        cmd.payload <= '0;
                        need        <= spec.nbytes;
                        got         <= '0;
                        idle_tmr    <= '0;
                        if (spec.nbytes == '0) begin
                            cmd_fire <= 1'b1;
                            state    <= P_BUSY;
                        end else begin
                            state    <= P_COLLECT;
                        end
                    end
                end
                P_COLLECT: begin
                    if (rx_valid) begin
                        cmd.payload <= {cmd.payload[PAYLOAD_W-BYTE_W-1:0], rx_data};
                        got         <= got + CNT_W'(1);
                        idle_tmr    <= '0;
                        if (got + CNT_W'(1) == need) begin
                            cmd_fire <= 1'b1;
                            state    <= P_BUSY;
                        end
                    end else if (idle_tmr == TMR_LAST) begin
                        state <= P_IDLE;
                    end else begin
                        idle_tmr <= idle_tmr + TMR_W'(1);
                    end
                end
                default: begin
                    if (reply_done) state <= P_IDLE;
                end
            endcase
        end
    end

    // R9: an expired idle window returns the parser to idle
    assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state == P_COLLECT && !rx_valid && idle_tmr == TMR_LAST) |=> (state == P_IDLE));

    // R7: an unknown address leaves the parser idle and fires nothing
    assert_unknown_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (state == P_IDLE && rx_valid && spec.kind == KIND_NONE) |=> (state == P_IDLE && !cmd_fire));
endmodule

// File: rtl/regcmd_reply.sv
module regcmd_reply
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_fire,
    input  reg_kind_e         kind,
    input  logic [REPLY_W-1:0] qry_data,
    input  logic [LEFT_W-1:0] qry_len,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              reply_done
);
    logic [REPLY_W-1:0] shreg;
    logic [LEFT_W-1:0]  left;
    logic               take;

    assign tx_valid   = (left != '0);
    assign tx_data    = shreg[REPLY_W-1 -: BYTE_W];
    assign take       = tx_valid && tx_ready;
    assign reply_done = take && (left == LEFT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            left  <= '0;
        end else if (cmd_fire) begin
            if (kind == KIND_CFG) begin
                shreg <= {ACK_BYTE, {(REPLY_W-BYTE_W){1'b0}}};
                left  <= LEFT_W'(1);
            end else begin
                shreg <= mask_reply(qry_data, qry_len);
                left  <= LEFT_W'(REPLY_BYTES);
            end
        end else if (take) begin
            shreg <= {shreg[REPLY_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            left  <= left - LEFT_W'(1);
        end
    end

    // R10: offered byte holds under back-pressure
    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R4: a configuration write loads the acknowledge byte
    assert_ack_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_fire && kind == KIND_CFG) |=> (tx_valid && tx_data == ACK_BYTE));

    // R5: the transmit line goes quiet after the last reply byte
    assert_reply_ends_R5: assert property (@(posedge clk) disable iff (rst)
        reply_done |=> !tx_valid);

    // R5: never more than eight bytes outstanding
    assert_reply_len_R5: assert property (@(posedge clk) disable iff (rst)
        left <= LEFT_W'(REPLY_BYTES));
endmodule

// File: rtl/regcmd_responder.sv
module regcmd_responder
    import regcmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        wr_strobe,
    output logic [7:0]  wr_addr,
    output logic [31:0] wr_data,
    output logic        qry_req,
    output logic [7:0]  qry_addr,
    output logic [31:0] qry_arg,
    input  logic [63:0] qry_data,
    input  logic [3:0]  qry_len
);
    cmd_t cmd;
    logic cmd_fire;
    logic reply_done;

    regcmd_parser #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .reply_done (reply_done),
        .cmd_fire   (cmd_fire),
        .cmd        (cmd)
    );

    regcmd_reply u_reply (
        .clk        (clk),
        .rst        (rst),
        .cmd_fire   (cmd_fire),
        .kind       (cmd.kind),
        .qry_data   (qry_data),
        .qry_len    (qry_len),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .reply_done (reply_done)
    );

    assign wr_strobe = cmd_fire && (cmd.kind == KIND_CFG);
    assign wr_addr   = cmd.addr;
    assign wr_data   = cmd.payload;
    assign qry_req   = cmd_fire && (cmd.kind == KIND_QRY);
    assign qry_addr  = cmd.addr;
    assign qry_arg   = cmd.payload;

    // R3: write strobe lasts one cycle
    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    // R8: no command executes while a reply is pending
    assert_no_exec_in_reply_R8: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !(wr_strobe || qry_req));
endmodule

// File: tb/sim_regcmd_responder.sv
module sim_regcmd_responder;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 20;

    // {address, data byte count, right-aligned data}
    localparam logic [42:0] VECS [0:7] = '{
        {8'h10, 3'd1, 32'h0000_00A7},
        {8'h11, 3'd2, 32'h0000_0000},
        {8'h12, 3'd4, 32'hDEAD_BEEF},
        {8'h20, 3'd1, 32'h0000_0000},
        {8'h20, 3'd1, 32'h0000_0001},
        {8'h20, 3'd1, 32'h0000_0002},
        {8'h21, 3'd0, 32'h0000_0000},
        {8'h11, 3'd2, 32'h0000_8001}
    };

    logic clk = 0, rst = 1;
    logic rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic tx_ready = 1;
    logic tx_valid, wr_strobe, qry_req;
    logic [7:0] tx_data, wr_addr, qry_addr;
    logic [31:0] wr_data, qry_arg;
    logic [63:0] qry_data;
    logic [3:0] qry_len;

    int chk_cnt = 0, err_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] model_data(input logic [7:0] a, input logic [7:0] g);
        return {a, g, 8'hA5, 8'h3C, ~a, g ^ 8'h5A, 8'h96, 8'h69};
    endfunction

    function automatic logic [3:0] model_len(input logic [7:0] a, input logic [7:0] g);
        if (a == 8'h21) return 4'd8;
        case (g)
            8'h00:   return 4'd7;
            8'h01:   return 4'd4;
            default: return 4'd2;
        endcase
    endfunction

    // expected k-th transmitted byte of a query reply (k=0 first)
    function automatic logic [7:0] exp_byte(input logic [7:0] a, input logic [7:0] g, input int k);
        logic [63:0] d;
        int idx;
        d = model_data(a, g);
        idx = 7 - k;
        if (idx < int'(model_len(a, g))) return d[idx*8 +: 8];
        return 8'h00;
    endfunction

    assign qry_data = model_data(qry_addr, qry_arg[7:0]);
    assign qry_len  = model_len(qry_addr, qry_arg[7:0]);

    regcmd_responder #(.TIMEOUT_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .qry_req(qry_req), .qry_addr(qry_addr), .qry_arg(qry_arg),
        .qry_data(qry_data), .qry_len(qry_len)
    );

    // observation logs
    logic [7:0]  tx_log [0:255];
    logic [7:0]  wa_log [0:63];
    logic [31:0] wd_log [0:63];
    logic [7:0]  qa_log [0:63];
    logic [31:0] qg_log [0:63];
    int tx_n = 0, wr_n = 0, q_n = 0, cyc = 0, rx_last = 0, wr_cyc = 0;

    always @(posedge clk) begin
        if (!rst) begin
            if (rx_valid) rx_last = cyc;
            if (wr_strobe) begin
                wa_log[wr_n[5:0]] = wr_addr;
                wd_log[wr_n[5:0]] = wr_data;
                wr_n = wr_n + 1;
                wr_cyc = cyc;
            end
            if (qry_req) begin
                qa_log[q_n[5:0]] = qry_addr;
                qg_log[q_n[5:0]] = qry_arg;
                q_n = q_n + 1;
            end
            if (tx_valid && tx_ready) begin
                tx_log[tx_n[7:0]] = tx_data;
                tx_n = tx_n + 1;
            end
        end
        cyc = cyc + 1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        chk_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic send_frame(input logic [7:0] a, input int n, input logic [31:0] d);
        send_byte(a);
        for (int k = 0; k < n; k++) send_byte(d[8*(n-1-k) +: 8]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            err_cnt++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, err_cnt);
            $finish;
        end
    end

    initial begin
        int tb, wb, qb;
        logic [7:0] held;
        idle(4);
        // R1: reset state
        check(!tx_valid && !wr_strobe && !qry_req, "R1", {tx_valid, wr_strobe, qry_req}, 0);
        @(negedge clk);
        rst = 0;
        idle(2);
        check(!tx_valid && !wr_strobe && !qry_req, "R1", {tx_valid, wr_strobe, qry_req}, 0);

        // table walk: R2 byte counts, R3/R4 writes, R5/R6 queries
        for (int v = 0; v < 8; v++) begin
            logic [7:0] a;
            int n;
            logic [31:0] d;
            a = VECS[v][42:35];
            n = int'(VECS[v][34:32]);
            d = VECS[v][31:0];
            tb = tx_n; wb = wr_n; qb = q_n;
            send_frame(a, n, d);
            idle(24);
            if (a < 8'h20) begin
                check(wr_n == wb + 1, "R2", wr_n - wb, 1);
                check(wa_log[wb[5:0]] == a && wd_log[wb[5:0]] == d, "R3",
                      {wa_log[wb[5:0]], wd_log[wb[5:0]]}, {a, d});
                check(wr_cyc == rx_last + 1, "R3", wr_cyc - rx_last, 1);
                check(tx_n == tb + 1 && tx_log[tb[7:0]] == 8'h02, "R4",
                      {tx_n - tb, tx_log[tb[7:0]]}, {32'd1, 8'h02});
            end else begin
                check(q_n == qb + 1 && wr_n == wb, "R2", q_n - qb, 1);
                check(qa_log[qb[5:0]] == a && qg_log[qb[5:0]] == d, "R5",
                      {qa_log[qb[5:0]], qg_log[qb[5:0]]}, {a, d});
                check(tx_n == tb + 8, "R5", tx_n - tb, 8);
                for (int k = 0; k < 8; k++)
                    check(tx_log[8'(tb + k)] == exp_byte(a, d[7:0], k), "R6",
                          tx_log[8'(tb + k)], exp_byte(a, d[7:0], k));
            end
        end

        // R7: unknown address dropped, next byte is an address
        tb = tx_n; wb = wr_n;
        send_byte(8'h55);
        send_frame(8'h10, 1, 32'h3C);
        idle(24);
        check(wr_n == wb + 1 && wd_log[wb[5:0]] == 32'h3C && wa_log[wb[5:0]] == 8'h10, "R7",
              wd_log[wb[5:0]], 32'h3C);
        check(tx_n == tb + 1, "R7", tx_n - tb, 1);

        // R10 and R8: stall a reply, send bytes meanwhile
        tb = tx_n; wb = wr_n; qb = q_n;
        tx_ready = 0;
        send_frame(8'h21, 0, 0);
        idle(3);
        held = tx_data;
        check(tx_valid && held == exp_byte(8'h21, 8'h00, 0), "R10", held, exp_byte(8'h21, 8'h00, 0));
        send_frame(8'h10, 1, 32'h77);
        idle(4);
        check(tx_valid && tx_data == held, "R10", tx_data, held);
        tx_ready = 1;
        idle(24);
        check(wr_n == wb && q_n == qb + 1, "R8", wr_n - wb, 0);
        check(tx_n == tb + 8, "R8", tx_n - tb, 8);
        for (int k = 0; k < 8; k++)
            check(tx_log[8'(tb + k)] == exp_byte(8'h21, 8'h00, k), "R10",
                  tx_log[8'(tb + k)], exp_byte(8'h21, 8'h00, k));
        // R8: parsing resumes after the reply
        wb = wr_n;
        send_frame(8'h10, 1, 32'h5E);
        idle(24);
        check(wr_n == wb + 1 && wd_log[wb[5:0]] == 32'h5E, "R8", wd_log[wb[5:0]], 32'h5E);

        // R9: short gap keeps the frame
        wb = wr_n;
        send_byte(8'h11);
        send_byte(8'hAB);
        idle(5);
        send_byte(8'hCD);
        idle(24);
        check(wr_n == wb + 1 && wd_log[wb[5:0]] == 32'hABCD, "R9", wd_log[wb[5:0]], 32'hABCD);

        // R9: long gap abandons the frame
        wb = wr_n; tb = tx_n;
        send_byte(8'h12);
        send_byte(8'h11);
        send_byte(8'h22);
        idle(2 * TMO);
        send_frame(8'h10, 1, 32'h99);
        idle(24);
        check(wr_n == wb + 1 && wa_log[wb[5:0]] == 8'h10 && wd_log[wb[5:0]] == 32'h99, "R9",
              {wa_log[wb[5:0]], wd_log[wb[5:0]]}, {8'h10, 32'h99});
        check(tx_n == tb + 1, "R9", tx_n - tb, 1);

        // R1: reset mid-reply clears outputs
        tx_ready = 0;
        send_frame(8'h21, 0, 0);
        idle(3);
        rst = 1;
        idle(2);
        check(!tx_valid && !wr_strobe && !qry_req, "R1", {tx_valid, wr_strobe, qry_req}, 0);
        rst = 0;
        tx_ready = 1;
        idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, err_cnt);
        $finish;
    end
endmodule